// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the wall-clock time and the calendar date as packed BCD registers. A prescaler counts pulses of a reference enable, nominally 32,768 per second, and turns them into a one-cycle second strobe. The strobe advances a carry chain: seconds, then minutes, hours, and the day. The day carry steps the day of week, the date, the month and the two-digit year. The last date of each month follows the month length, and February gains a 29th day in leap years. The strobe is also an output, so alarm logic can compare fields once per second.

Hours can run in a 24-hour format or a 12-hour format with an AM/PM flag. The format is chosen per write through the hours register itself. Software loads any field through a synchronous write port, and reads any field through a combinational read port. A control register holds a write-protect bit and the enable for a 1 Hz square-wave output. The output is modelled as a data line plus an output-enable line.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read 00 seconds, 00 minutes, hours 00 in 24-hour format, day of week 01, date 01, month 01, year 00. The control register reads 00, the square-wave enable is low, and no second strobe is present.
- R2: Every PRESCALE-th `ref_tick` produces a `sec_strobe` of exactly one cycle. Seconds count 00-59 and minutes count 00-59. Each wraps to 00 and carries into the next field.
- R3: With hours bit 6 at 0 (24-hour format), bits 5:0 hold BCD hours 00-23. Hour 23 wraps to 00 and advances the day.
- R4: With hours bit 6 at 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01-12. Hour 11 goes to 12 and inverts PM. Hour 12 goes to 01 and keeps PM. 11 PM going to 12 AM advances the day.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R6: February ends at 29 when the BCD year is a multiple of four, and at 28 otherwise.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: The day of week counts 01-07 and wraps from 07 to 01 on the same day carry that advances the date.
- R9: Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control. Unused bits read back 0 whatever was written. The used bits per register are: seconds, minutes and hours bits 6:0; day of week bits 2:0; date bits 5:0; month bits 4:0; year bits 7:0; control bits 7 and 0.
- R10: Control bit 7 is write-protect. While it is 1, writes to addresses 0-6 are ignored, and a control write updates only bit 7.
- R11: Control bit 0 drives `sq_oe`. `sq_out` is high during the first half of each second's prescaler count (high straight after reset) and low in the second half.
- R12: A field write in the cycle of `sec_strobe` wins for that field. Every other field advances as the strobe demands, with carries computed from the old value of the written field.
- R13: A write loads its field on the next clock edge, and the following strobes count on from the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (R9 map) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address (R9 map) |
| rd_data | output | 8 | Combinational read data |
| sec_strobe | output | 1 | One-cycle pulse per second |
| sq_out | output | 1 | 1 Hz square-wave data |
| sq_oe | output | 1 | Output enable of the square wave |

## Verification
A software write and the second strobe can land on the same edge. The written field and the carry chain then both want to change the registers. The bench provokes this by holding `wr_en` in the exact cycle where it has just observed `sec_strobe` high. It does this once on the minutes field and once on the seconds field while seconds sit at 59. The result is judged against a model that first advances the whole time by one second from the old values, then overwrites the written field. So the minutes must still take the carry out of an overwritten 59 seconds.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
   localparam int unsigned FIELD_W = 8;
   localparam int unsigned ADDR_W  = 3;
   localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
   localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
   localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
   localparam logic [ADDR_W-1:0] A_DOW   = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATE  = 3'd4;
   localparam logic [ADDR_W-1:0] A_MONTH = 3'd5;
   localparam logic [ADDR_W-1:0] A_YEAR  = 3'd6;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd7;

   // BCD increment with wrap from hi back to lo
   function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                           input logic [7:0] lo,
                                           input logic [7:0] hi);
      if (v >= hi)
         return lo;
      if (v[3:0] >= 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // two-digit BCD year divisible by four
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4])
         return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] m,
                                             input logic [7:0] y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   output logic sec_pulse,
   output logic half_hi
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam logic [CW-1:0] HALF = CW'(DIV / 2);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("rtc_prescaler: DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         sec_pulse <= 1'b0;
      end else begin
         sec_pulse <= ref_tick && (cnt == LAST);
         if (ref_tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign half_hi = (cnt < HALF);

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !sec_pulse);                                     // R2
   AST_PULSE_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_pulse) |-> $past(ref_tick));                         // R2
endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
   parameter logic [7:0] LO   = 8'h00,
   parameter logic [7:0] HI   = 8'h59,
   parameter logic [7:0] MASK = 8'h7F
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       load,
   input  logic [7:0] load_val,
   output logic [7:0] value,
   output logic       carry
);
   generate
      if (LO >= HI) begin : g_bad_range
         $error("rtc_wrap_counter: LO must be below HI");
      end
   endgenerate

   assign carry = step && (value >= HI);

   always_ff @(posedge clk) begin
      if (!rst_n)
         value <= LO;
      else if (load)
         value <= load_val & MASK;
      else if (step)
         value <= rtc_core_pkg::bcd_next(value, LO, HI);
   end

   AST_WRAP_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && value == HI) |=> (value == LO));             // R2
endmodule

// File: rtl/rtc_hour_counter.sv
module rtc_hour_counter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       load,
   input  logic [7:0] load_val,
   output logic [7:0] value,
   output logic       carry
);
   logic       mode12;
   logic       pm;
   logic [7:0] inc12;
   logic [7:0] inc24;
   logic [7:0] nxt;

   assign mode12 = value[6];
   assign pm     = value[5];
   assign inc12  = rtc_core_pkg::bcd_next({3'b000, value[4:0]}, 8'h01, 8'h12);
   assign inc24  = rtc_core_pkg::bcd_next({2'b00, value[5:0]}, 8'h00, 8'h23);

   always_comb begin
      nxt   = value;
      carry = 1'b0;
      if (mode12) begin
         if (value[4:0] == 5'h11) begin
            nxt   = {2'b01, ~pm, 5'h12};
            carry = step && pm;
         end else if (value[4:0] >= 5'h12) begin
            nxt = {2'b01, pm, 5'h01};
         end else begin
            nxt = {2'b01, pm, 5'h00} | (inc12 & 8'h1F);
         end
      end else begin
         nxt   = inc24;
         carry = step && (value[5:0] >= 6'h23);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         value <= 8'h00;
      else if (load)
         value <= load_val & 8'h7F;
      else if (step)
         value <= nxt;
   end

   AST_H24_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !value[6] && value[5:0] == 6'h23) |=> (value == 8'h00)); // R3
   AST_H12_NOON: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && value[6] && value[4:0] == 5'h11)
      |=> (value[4:0] == 5'h12 && value[5] != $past(value[5])));     // R4
   AST_H12_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && value[6] && value[4:0] == 5'h12)
      |=> (value[4:0] == 5'h01 && $stable(value[5])));               // R4
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       day_step,
   input  logic       ld_dow,
   input  logic       ld_date,
   input  logic       ld_month,
   input  logic       ld_year,
   input  logic [7:0] wr_val,
   output logic [7:0] dow,
   output logic [7:0] date,
   output logic [7:0] month,
   output logic [7:0] year
);
   logic [7:0] last_date;
   logic       date_carry;
   logic       month_carry;
   logic       year_carry;
   logic       dow_carry;

   assign last_date  = rtc_core_pkg::month_last(month, year);
   assign date_carry = day_step && (date >= last_date);

   always_ff @(posedge clk) begin
      if (!rst_n)
         date <= 8'h01;
      else if (ld_date)
         date <= wr_val & 8'h3F;
      else if (day_step)
         date <= (date >= last_date) ? 8'h01
                 : rtc_core_pkg::bcd_next(date, 8'h01, 8'h31);
   end

   rtc_wrap_counter #(.LO(8'h01), .HI(8'h07), .MASK(8'h07)) u_dow (
      .clk(clk), .rst_n(rst_n), .step(day_step), .load(ld_dow),
      .load_val(wr_val), .value(dow), .carry(dow_carry));

   rtc_wrap_counter #(.LO(8'h01), .HI(8'h12), .MASK(8'h1F)) u_month (
      .clk(clk), .rst_n(rst_n), .step(date_carry), .load(ld_month),
      .load_val(wr_val), .value(month), .carry(month_carry));

   rtc_wrap_counter #(.LO(8'h00), .HI(8'h99), .MASK(8'hFF)) u_year (
      .clk(clk), .rst_n(rst_n), .step(month_carry), .load(ld_year),
      .load_val(wr_val), .value(year), .carry(year_carry));

   AST_DATE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (day_step && !ld_date && date == last_date) |=> (date == 8'h01)); // R5
   AST_LEAP_FEB: assert property (@(posedge clk) disable iff (!rst_n)
      (day_step && !ld_date && month == 8'h02 && date == 8'h28
       && rtc_core_pkg::bcd_leap(year)) |=> (date == 8'h29));         // R6
   AST_YEAR_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
      (year_carry && !ld_year) |=> (year == 8'h00));                  // R7
   AST_DOW_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
      (dow_carry && !ld_dow) |=> (dow == 8'h01));                     // R8
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
   parameter int unsigned PRESCALE = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_tick,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       sec_strobe,
   output logic       sq_out,
   output logic       sq_oe
);
   import rtc_core_pkg::*;

   localparam int unsigned N_SM = 2;   // seconds and minutes share one counter shape

   logic            wp_q;
   logic            sqen_q;
   logic            wr_ok;
   logic [7:0]      ld;
   logic [N_SM-1:0] sm_step;
   logic [N_SM-1:0] sm_carry;
   logic [7:0]      sm_val [N_SM];
   logic [7:0]      hour;
   logic            day_carry;
   logic [7:0]      dow, date, month, year;

   assign wr_ok = wr_en && !wp_q;

   always_comb begin
      ld = '0;
      if (wr_ok)
         ld[wr_addr] = 1'b1;
   end

   rtc_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .sec_pulse(sec_strobe), .half_hi(sq_out));

   assign sm_step[0] = sec_strobe;
   assign sm_step[1] = sm_carry[0];

   genvar gi;
   generate
      for (gi = 0; gi < N_SM; gi++) begin : g_sm
         rtc_wrap_counter #(.LO(8'h00), .HI(8'h59), .MASK(8'h7F)) u_cnt (
            .clk(clk), .rst_n(rst_n), .step(sm_step[gi]), .load(ld[gi]),
            .load_val(wr_data), .value(sm_val[gi]), .carry(sm_carry[gi]));
      end
   endgenerate

   rtc_hour_counter u_hour (
      .clk(clk), .rst_n(rst_n), .step(sm_carry[1]), .load(ld[A_HOUR]),
      .load_val(wr_data), .value(hour), .carry(day_carry));

   rtc_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .day_step(day_carry),
      .ld_dow(ld[A_DOW]), .ld_date(ld[A_DATE]), .ld_month(ld[A_MONTH]),
      .ld_year(ld[A_YEAR]), .wr_val(wr_data),
      .dow(dow), .date(date), .month(month), .year(year));

   // control: protect bit always writable, enable only while unprotected
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= 1'b0;
         sqen_q <= 1'b0;
      end else if (wr_en && wr_addr == A_CTRL) begin
         wp_q <= wr_data[7];
         if (!wp_q)
            sqen_q <= wr_data[0];
      end
   end

   assign sq_oe = sqen_q;

   always_comb begin
      case (rd_addr)
         A_SEC:   rd_data = sm_val[0];
         A_MIN:   rd_data = sm_val[1];
         A_HOUR:  rd_data = hour;
         A_DOW:   rd_data = dow;
         A_DATE:  rd_data = date;
         A_MONTH: rd_data = month;
         A_YEAR:  rd_data = year;
         default: rd_data = {wp_q, 6'b000000, sqen_q};
      endcase
   end

   AST_WP_HOLDS_YEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_q && wr_en && wr_addr == A_YEAR && !sec_strobe) |=> $stable(year)); // R10
   AST_WP_HOLDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_q && wr_en && wr_addr == A_CTRL) |=> $stable(sq_oe));       // R10
   AST_MIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wp_q && wr_addr == A_MIN)
      |=> (sm_val[1] == ($past(wr_data) & 8'h7F)));                   // R12
endmodule

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       sec_strobe, sq_out, sq_oe;

   always #4 clk = ~clk;

   bcd_rtc_core #(.PRESCALE(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .sec_strobe(sec_strobe), .sq_out(sq_out),
      .sq_oe(sq_oe));

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   // model state in plain integers
   int s, m, h, mode12, dw, dt, mo, yr;

   function automatic logic [7:0] bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(int mon, int y);
      case (mon)
         4, 6, 9, 11: return 30;
         2:           return (y % 4 == 0) ? 29 : 28;
         default:     return 31;
      endcase
   endfunction

   function automatic logic [7:0] hour_enc(int hh, int md);
      int h12;
      if (md == 0) return bcd(hh);
      h12 = (hh % 12 == 0) ? 12 : hh % 12;
      return 8'h40 | ((hh >= 12) ? 8'h20 : 8'h00) | bcd(h12);
   endfunction

   task automatic model_sec();
      s++;
      if (s == 60) begin s = 0; m++; end
      if (m == 60) begin m = 0; h++; end
      if (h == 24) begin
         h = 0;
         dw = (dw == 7) ? 1 : dw + 1;
         dt++;
         if (dt > dim(mo, yr)) begin
            dt = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
         end
      end
   endtask

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic check_reg(string tag, logic [2:0] a, logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic check_time(string tag);
      check_reg({tag, " sec"},   3'd0, bcd(s));
      check_reg({tag, " min"},   3'd1, bcd(m));
      check_reg({tag, " hour"},  3'd2, hour_enc(h, mode12));
      check_reg({tag, " dow"},   3'd3, bcd(dw));
      check_reg({tag, " date"},  3'd4, bcd(dt));
      check_reg({tag, " month"}, 3'd5, bcd(mo));
      check_reg({tag, " year"},  3'd6, bcd(yr));
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_all();
      wr(3'd0, bcd(s));  wr(3'd1, bcd(m)); wr(3'd2, hour_enc(h, mode12));
      wr(3'd3, bcd(dw)); wr(3'd4, bcd(dt)); wr(3'd5, bcd(mo)); wr(3'd6, bcd(yr));
   endtask

   task automatic ref_pulse();
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
   endtask

   // one second; optional write in the strobe cycle
   task automatic advance(bit do_wr, logic [2:0] a, logic [7:0] d);
      repeat (DIV) ref_pulse();
      n_chk++;
      if (sec_strobe !== 1'b1) begin
         n_fail++;
         $display("FAIL R2 strobe actual=%b expected=1", sec_strobe);
      end
      if (do_wr) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
      @(negedge clk);
      wr_en = 1'b0;
      n_chk++;
      if (sec_strobe !== 1'b0) begin
         n_fail++;
         $display("FAIL R2 strobe width actual=%b expected=0", sec_strobe);
      end
      model_sec();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      s = 0; m = 0; h = 0; mode12 = 0; dw = 1; dt = 1; mo = 1; yr = 0;
      // R1 reset state
      check_time("R1");
      check_reg("R1 ctrl", 3'd7, 8'h00);
      check("R1 oe", {7'b0, sq_oe}, 8'h00);
      check("R1 strobe", {7'b0, sec_strobe}, 8'h00);

      // R11 square wave halves and enable
      check("R11 sq first half", {7'b0, sq_out}, 8'h01);
      ref_pulse(); ref_pulse();
      check("R11 sq second half", {7'b0, sq_out}, 8'h00);
      ref_pulse(); ref_pulse();
      @(negedge clk);
      model_sec();
      check("R11 sq wraps high", {7'b0, sq_out}, 8'h01);
      check_reg("R2 first second", 3'd0, 8'h01);
      wr(3'd7, 8'h01);
      check("R11 oe on", {7'b0, sq_oe}, 8'h01);
      wr(3'd7, 8'h00);
      check("R11 oe off", {7'b0, sq_oe}, 8'h00);

      // R13 load then count, R2 minute carry
      s = 58; m = 0; h = 0; load_all();
      check_time("R13 loaded");
      advance(0, 0, 0); advance(0, 0, 0);
      check_reg("R2 sec wrap", 3'd0, 8'h00);
      check_reg("R2 min carry", 3'd1, 8'h01);

      // R3 R7 R8: new year's midnight
      s = 59; m = 59; h = 23; dw = 7; dt = 31; mo = 12; yr = 99; load_all();
      advance(0, 0, 0);
      check_time("R3 R7 R8 rollover");
      check_reg("R8 dow wrap", 3'd3, 8'h01);
      check_reg("R7 year wrap", 3'd6, 8'h00);

      // R4 twelve-hour sequence
      mode12 = 1; s = 59; m = 59; h = 11; dw = 3; dt = 10; mo = 5; yr = 21; load_all();
      advance(0, 0, 0);
      check_reg("R4 11AM->12PM", 3'd2, 8'h72);
      s = 59; m = 59; h = 12; load_all();
      advance(0, 0, 0);
      check_reg("R4 12PM->01PM", 3'd2, 8'h61);
      s = 59; m = 59; h = 23; load_all();
      advance(0, 0, 0);
      check_reg("R4 11PM->12AM", 3'd2, 8'h52);
      check_time("R4 day carry");
      mode12 = 0;

      // R5 month lengths
      s = 59; m = 59; h = 23; dt = 30; mo = 4; yr = 22; load_all();
      advance(0, 0, 0);
      check_time("R5 april end");
      s = 59; m = 59; h = 23; dt = 30; mo = 1; load_all();
      advance(0, 0, 0);
      check_reg("R5 jan 31", 3'd4, 8'h31);

      // R6 leap February
      s = 59; m = 59; h = 23; dt = 28; mo = 2; yr = 24; load_all();
      advance(0, 0, 0);
      check_reg("R6 leap 29", 3'd4, 8'h29);
      s = 59; m = 59; h = 23; dt = 28; mo = 2; yr = 23; load_all();
      advance(0, 0, 0);
      check_time("R6 common year");
      s = 59; m = 59; h = 23; dt = 29; mo = 2; yr = 0; load_all();
      advance(0, 0, 0);
      check_time("R6 year 00");

      // R12 write in the strobe cycle
      s = 59; m = 10; h = 5; load_all();
      advance(1, 3'd1, 8'h33);
      m = 33;
      check_time("R12 min write wins");
      s = 59; m = 5; load_all();
      advance(1, 3'd0, 8'h20);
      s = 20;
      check_time("R12 sec write keeps carry");

      // R9 fixed-zero bits
      wr(3'd0, 8'hFF); check_reg("R9 sec", 3'd0, 8'h7F);
      wr(3'd3, 8'hFF); check_reg("R9 dow", 3'd3, 8'h07);
      wr(3'd4, 8'hFF); check_reg("R9 date", 3'd4, 8'h3F);
      wr(3'd5, 8'hFF); check_reg("R9 month", 3'd5, 8'h1F);
      wr(3'd7, 8'h7E); check_reg("R9 ctrl", 3'd7, 8'h00);
      load_all();

      // R10 write protect
      wr(3'd7, 8'h80);
      check_reg("R10 wp set", 3'd7, 8'h80);
      wr(3'd6, 8'h55);
      check_reg("R10 year blocked", 3'd6, bcd(yr));
      wr(3'd1, 8'h44);
      check_reg("R10 min blocked", 3'd1, bcd(m));
      wr(3'd7, 8'h81);
      check_reg("R10 enable blocked", 3'd7, 8'h80);
      check("R10 oe stays", {7'b0, sq_oe}, 8'h00);
      wr(3'd7, 8'h01);
      check_reg("R10 wp cleared only", 3'd7, 8'h00);
      wr(3'd6, 8'h55); yr = 55;
      check_reg("R10 write after clear", 3'd6, 8'h55);

      // random near-carry starts, R13 counting onward
      for (int it = 0; it < 30; it++) begin
         mode12 = $urandom % 2;
         s  = 55 + ($urandom % 5);
         m  = ($urandom % 2) ? 59 : ($urandom % 60);
         h  = ($urandom % 2) ? 23 : ($urandom % 24);
         mo = 1 + ($urandom % 12);
         yr = $urandom % 100;
         dt = ($urandom % 2) ? dim(mo, yr) : 1 + ($urandom % dim(mo, yr));
         dw = 1 + ($urandom % 7);
         load_all();
         n = 1 + ($urandom % 6);
         for (int k = 0; k < n; k++) advance(0, 0, 0);
         check_time("R13 random");
      end

      finish_run();
   end
endmodule